// File: doc/BRIEF.md
# Recursive Quadrature Oscillator

This block produces a continuous pair of sinusoids, one sine and one cosine, exactly a quarter period apart, at one new sample pair per clock. The pair is generated by a marginally stable second-order recurrence whose poles lie on the unit circle. Each new sample is twice the coefficient times the current sample, less the sample before it. Each of the two channels keeps its own pair of state registers and uses a single multiplier. The two channels share one coefficient and differ only in how their state is seeded.

A 4-bit select picks the step angle from a built-in set of sixteen, spaced 15 degrees apart (0 to 225 degrees). Leaving reset, or changing the select, seeds both channels so that the stream restarts at phase zero. A valid flag marks the cycles in which the outputs carry samples.

Top module: `quad_osc`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, `valid_o` is 0 and both `sin_o` and `cos_o` are 0.
- R2: On the first clock edge after reset is released, `valid_o` becomes 1, and it stays 1 until the next reset.
- R3: On any edge where the block is not yet valid, or where `angle_sel_i` differs from the select in use, the block reloads. After that edge `cos_o` is 32'h40000000 (1.0) and `sin_o` is 0, and sample index n restarts at 0.
- R4: Both outputs are two's complement signed 32-bit values with 30 fraction bits and 2 integer bits, so -1.0 reads as 32'hC0000000.
- R5: With a steady select k, sample n (counted from the reload) is close to cos(n·θ)·2^30 on `cos_o` and to sin(n·θ)·2^30 on `sin_o`, where θ = 15°·k. It stays within 2^14 LSB for at least the first 32 samples.
- R6: The coefficient for select k is cos(15°·k) truncated toward zero to the 30-fraction-bit format. For select 2 it is 32'h376CF5D1, and this value appears exactly as `cos_o` at sample 1.
- R7: With select 0, `cos_o` stays exactly 32'h40000000 and `sin_o` stays exactly 0.
- R8: With select 6 (90°) and select 12 (180°), both outputs are exact. Select 6 cycles through 1, 0, -1, 0 on the cosine and 0, 1, 0, -1 on the sine. Select 12 alternates the cosine between +1 and -1 while the sine stays 0.
- R9: While the select is held, each edge advances the recurrence by exactly one sample with no restart. The previous-sample register of each channel takes the current sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle_sel_i | input | 4 | Step-angle select, θ = 15°·value |
| sin_o | output | 32 | Sine sample, signed, 30 fraction bits |
| cos_o | output | 32 | Cosine sample, signed, 30 fraction bits |
| valid_o | output | 1 | High while the outputs carry samples |

## Verification
The sweep visits every select and follows each one for 32 samples. It compares both channels against a real-valued reference, so a wrong table entry, a missing doubling or a sign slip in the subtraction shows up within a few samples as a large error. The selects whose results are exact (0, 90 and 180 degrees) are checked with zero tolerance. This catches truncation in the wrong place or mishandled wrap: at 0 degrees the doubled product reaches +2.0 and must wrap back correctly. Every select change is checked to restart at cos 1.0 and sin 0 on the very next sample. A design that failed to reload would keep running at the old phase. Exact sample 1 for the 30-degree select pins the coefficient word itself.

// File: rtl/quad_osc_pkg.sv
package quad_osc_pkg;

  localparam int DATA_W   = 32;
  localparam int FRAC_W   = 30;
  localparam int SEL_W    = 4;
  localparam int NUM_ANG  = 1 << SEL_W;
  // angle step is 15 degrees: 24 steps per full turn
  localparam int TURN     = 24;
  localparam int QUARTER  = TURN / 4;
  localparam int HALF     = TURN / 2;

  // cos(15 deg * j) for j = 0..6, Q2.30, truncated toward zero
  function automatic logic signed [DATA_W-1:0] base_mag(input int j);
    case (j)
      0:       return 32'sh4000_0000;
      1:       return 32'sh3DD1_BA8E;
      2:       return 32'sh376C_F5D1;
      3:       return 32'sh2D41_3CCC;
      4:       return 32'sh2000_0000;
      5:       return 32'sh1090_7DC1;
      default: return '0;
    endcase
  endfunction

  // cos(15 deg * m) for any integer m, folded onto the first quadrant
  function automatic logic signed [DATA_W-1:0] cos_steps(input int m);
    int a;
    a = (m < 0) ? -m : m;
    a = a % TURN;
    if (a > HALF) a = TURN - a;
    if (a > QUARTER) return -base_mag(HALF - a);
    return base_mag(a);
  endfunction

endpackage

// File: rtl/osc_coef_rom.sv
module osc_coef_rom
  import quad_osc_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int SW  = SEL_W,
  localparam int N  = 1 << SW
) (
  input  logic [SW-1:0]        sel_i,
  output logic signed [DW-1:0] coef_o,     // cos(theta)
  output logic signed [DW-1:0] neg_sin_o   // sin(-theta) = cos(theta + 90)
);

  logic signed [DW-1:0] cos_tbl  [N];
  logic signed [DW-1:0] nsin_tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign cos_tbl[g]  = DW'(cos_steps(g));
    assign nsin_tbl[g] = DW'(cos_steps(g + QUARTER));
  end

  assign coef_o    = cos_tbl[sel_i];
  assign neg_sin_o = nsin_tbl[sel_i];

endmodule

// File: rtl/osc_recursion.sv
module osc_recursion #(
  parameter int DW = 32,
  parameter int FW = 30,
  localparam int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 advance_i,
  input  logic signed [DW-1:0] coef_i,
  input  logic signed [DW-1:0] init_cur_i,
  input  logic signed [DW-1:0] init_prev_i,
  output logic signed [DW-1:0] sample_o
);

  logic signed [DW-1:0] cur_q, prev_q;
  logic signed [DW-1:0] cur_d, prev_d;
  logic signed [PW-1:0] prod;
  logic signed [DW-1:0] twice_q;
  logic                 unused_prod_bits;

  // single multiply; doubling folded into the slice, one truncation
  assign prod    = coef_i * cur_q;
  assign twice_q = prod[FW+DW-2:FW-1];
  assign unused_prod_bits = ^{prod[PW-1:FW+DW-1], prod[FW-2:0]};

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    if (load_i) begin
      cur_d  = init_cur_i;
      prev_d = init_prev_i;
    end else if (advance_i) begin
      cur_d  = twice_q - prev_q;   // wraps modulo 4.0 by design
      prev_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (load_i || advance_i) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign sample_o = cur_q;

  // R9: prior sample moves into the delay register on each step
  a_r9_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i) |=> (prev_q == $past(cur_q)));

endmodule

// File: rtl/quad_osc.sv
module quad_osc
  import quad_osc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W,
  parameter int SW = SEL_W,
  localparam logic signed [DW-1:0] UNITY = DW'(1) <<< FW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW-1:0]        angle_sel_i,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o,
  output logic                 valid_o
);

  logic [SW-1:0]        angle_q, angle_d;
  logic                 valid_q, valid_d;
  logic                 reload, advance;
  logic signed [DW-1:0] coef, neg_sin;
  logic signed [DW-1:0] init_cur  [2];
  logic signed [DW-1:0] init_prev [2];
  logic signed [DW-1:0] path_out  [2];

  osc_coef_rom #(.DW(DW), .SW(SW)) u_rom (
    .sel_i     (angle_sel_i),
    .coef_o    (coef),
    .neg_sin_o (neg_sin)
  );

  assign reload  = !valid_q || (angle_sel_i != angle_q);
  assign advance = !reload;

  always_comb begin
    angle_d = angle_q;
    valid_d = valid_q;
    if (reload) begin
      angle_d = angle_sel_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      valid_q <= 1'b0;
    end else if (reload) begin
      angle_q <= angle_d;
      valid_q <= valid_d;
    end
  end

  // path 0: cosine, seeded 1.0 / cos(-theta); path 1: sine, seeded 0 / sin(-theta)
  assign init_cur[0]  = UNITY;
  assign init_prev[0] = coef;
  assign init_cur[1]  = '0;
  assign init_prev[1] = neg_sin;

  for (genvar p = 0; p < 2; p++) begin : g_path
    osc_recursion #(.DW(DW), .FW(FW)) u_rec (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (reload),
      .advance_i   (advance),
      .coef_i      (coef),
      .init_cur_i  (init_cur[p]),
      .init_prev_i (init_prev[p]),
      .sample_o    (path_out[p])
    );
  end

  assign cos_o   = valid_q ? path_out[0] : '0;
  assign sin_o   = valid_q ? path_out[1] : '0;
  assign valid_o = valid_q;

  // R1: nothing but zeros before the first load
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (sin_o == '0 && cos_o == '0));

  // R2: valid never drops outside reset
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  // R3: reload restarts at phase zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cos_o == UNITY && sin_o == '0));

  // R7: zero step angle holds the origin
  a_r7_still: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && angle_q == '0) |-> (cos_o == UNITY && sin_o == '0));

  // R8: half-turn step flips the cosine sign exactly
  a_r8_half_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && angle_q == SW'(HALF) && $past(angle_q) == SW'(HALF))
      |-> (cos_o == -$past(cos_o) && sin_o == '0));

endmodule

// File: tb/sim_quad_osc.sv
`timescale 1ns/1ps
module sim_quad_osc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  angle_sel;
  logic [31:0] sin_w, cos_w;
  logic        valid_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam int    ONE   = 32'h4000_0000;
  localparam int    TOL   = 1 << 14;
  localparam int    NSAMP = 32;
  localparam real   PI    = 3.14159265358979323846;

  always #10 clk = ~clk;

  quad_osc u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .angle_sel_i (angle_sel),
    .sin_o       (sin_w),
    .cos_o       (cos_w),
    .valid_o     (valid_w)
  );

  task automatic chk(input string req, input int act, input int exp, input int tol);
    longint d;
    d = longint'(act) - longint'(exp);
    if (d < 0) d = -d;
    checks++;
    if (d > longint'(tol)) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h) tol=%0d",
               req, act, act, exp, exp, tol);
    end
  endtask

  function automatic int to_q30(input real x);
    real s;
    s = x * 1073741824.0;
    return $rtoi(s >= 0.0 ? s + 0.5 : s - 0.5);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    angle_sel = 4'd5;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", int'(valid_w), 0, 0);
    chk("R1 sin in reset", int'($signed(sin_w)), 0, 0);
    chk("R1 cos in reset", int'($signed(cos_w)), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2, R3: first edge after release loads phase zero
    chk("R2 valid after release", int'(valid_w), 1, 0);
    chk("R3 cos first sample", int'($signed(cos_w)), ONE, 0);
    chk("R3 sin first sample", int'($signed(sin_w)), 0, 0);
    @(negedge clk);
    chk("R5 cos sel5 n1", int'($signed(cos_w)), to_q30($cos(75.0 * PI / 180.0)), TOL);
    chk("R5 sin sel5 n1", int'($signed(sin_w)), to_q30($sin(75.0 * PI / 180.0)), TOL);

    // exhaustive sweep of every select
    for (int k = 0; k < 16; k++) begin
      real th;
      th = real'(k) * 15.0 * PI / 180.0;
      angle_sel = 4'(k);
      for (int n = 0; n < NSAMP; n++) begin
        int ec, es, tol;
        string tag;
        @(negedge clk);
        ec  = to_q30($cos(real'(n) * th));
        es  = to_q30($sin(real'(n) * th));
        tol = (k == 0 || k == 6 || k == 12) ? 0 : TOL;
        if (n == 0)                 tag = "R3 restart";
        else if (k == 0)            tag = "R7 zero angle";
        else if (k == 12 && n == 1) tag = "R4 negative one";
        else if (k == 6 || k == 12) tag = "R8 exact angle";
        else if (n == NSAMP - 1)    tag = "R9 no restart";
        else                        tag = "R5 tracking";
        if (n == 0) begin
          ec = ONE;
          es = 0;
        end
        if (k == 2 && n == 1) begin
          chk("R6 coefficient word", int'($signed(cos_w)), 32'h376C_F5D1, 0);
        end
        chk("R2 valid held", int'(valid_w), 1, 0);
        chk({tag, " cos"}, int'($signed(cos_w)), ec, tol);
        chk({tag, " sin"}, int'($signed(sin_w)), es, tol);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule